// File: doc/BRIEF.md
# Low-Power Sleep Mode Controller

This block decides when the clock of a small 8-bit CPU core may stop. It watches the opcodes leaving the fetch stage and recognises two sleep instructions. Opcode 0x7F requests a light sleep: the core clock stops, while the oscillator, the timer clock and the interrupt inputs stay live. Opcode 0x6F requests a deep sleep: the core clock, the timer clock and the oscillator all stop. A sleep opcode is honoured at once only when the valid opcode just before it was the no-op 0xFF. In that case the pipeline is known to be empty. Without that no-op, the controller holds the core running until the core reports an empty pipeline, and it records the slip in a sticky flag.

The state machine has six states. ST_RUN is normal execution. ST_FLUSH_L and ST_FLUSH_D wait for the pipeline to empty before light or deep sleep. ST_LIGHT is light sleep and ST_DEEP is deep sleep. ST_WARM waits for the oscillator to stabilise.

Its transitions are as follows:
- ST_RUN goes to ST_LIGHT or ST_DEEP on a sleep opcode that follows a no-op.
- ST_RUN goes to ST_FLUSH_L or ST_FLUSH_D on a sleep opcode that does not follow a no-op.
- ST_FLUSH_L goes to ST_LIGHT, and ST_FLUSH_D goes to ST_DEEP, when the pipeline reports empty.
- ST_LIGHT goes to ST_RUN on an enabled interrupt request.
- ST_DEEP goes to ST_WARM on a reset wake.
- ST_WARM goes to ST_RUN when the warm-up count expires.

A wake from light sleep pulses `wake_irq`. The core then takes the interrupt and afterwards continues after the sleep opcode. The end of warm-up pulses `wake_rst`, and the core then restarts at `restart_pc` (0x000C). The core clock is produced by a glitch-free gate whose enable is latched while the controller clock is low.

Top module: `slp_ctrl`

## Requirements
- R1: While reset is held and in the cycle after reset is released, the outputs are as follows. `mode` is 2'b00 (run). `cpu_clk_en`, `osc_en` and `tmr_clk_en` are 1. `flush_miss`, `wake_irq` and `wake_rst` are 0. `restart_pc` is 16'h000C at all times.
- R2: Suppose a valid opcode 0x7F follows a valid opcode 0xFF. From the next cycle, `mode` is 2'b01 (light), `cpu_clk_en` is 0, and `osc_en` and `tmr_clk_en` stay 1.
- R3: Suppose a valid opcode 0x6F follows a valid opcode 0xFF. From the next cycle, `mode` is 2'b10 (deep), and `cpu_clk_en`, `osc_en` and `tmr_clk_en` are all 0.
- R4: Light sleep ends in the cycle after any bit of `irq_req & irq_en` is 1. `mode` then returns to 2'b00, `cpu_clk_en` to 1, and `wake_irq` pulses high for exactly one cycle. Requests whose `irq_en` bit is 0 leave the block asleep.
- R5: In deep sleep, interrupt requests have no effect. `rst_wake` moves the block in the next cycle to warm-up: `mode` 2'b11, `osc_en` 1, `cpu_clk_en` 0, `tmr_clk_en` 0.
- R6: Warm-up lasts exactly WARM_CYCLES cycles. Then `mode` returns to 2'b00, all enables return to 1, and `wake_rst` pulses high for one cycle.
- R7: Consider a sleep opcode whose preceding valid opcode was not 0xFF. It sets `flush_miss` from the next cycle, and `flush_miss` stays set until reset. The block keeps `mode` 2'b00 and `cpu_clk_en` 1 until `pipe_empty` is sampled high. It enters the requested sleep in the following cycle.
- R8: During each high phase of `clk`, `cpu_clk` follows `clk` only if `cpu_clk_en` was 1 in the preceding low phase. It never starts or ends a pulse partway through a high phase.
- R9: In the run state, `rst_wake` and enabled interrupt requests have no effect: no wake pulse and no change of `mode`. In light sleep, `rst_wake` has no effect.
- R10: Cycles with `fetch_valid` low do not break the no-op/sleep pairing. Any other valid opcode between 0xFF and the sleep opcode does break it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock (oscillator domain) |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| fetch_valid | input | 1 | An opcode is presented by the fetch stage this cycle |
| fetch_op | input | 8 | Opcode from the fetch stage |
| pipe_empty | input | 1 | Core reports its instruction pipeline is empty |
| irq_req | input | NUM_IRQ | Interrupt request lines |
| irq_en | input | NUM_IRQ | Per-line enable for execution |
| rst_wake | input | 1 | Reset wake event, acts only in deep sleep |
| cpu_clk | output | 1 | Gated core clock |
| cpu_clk_en | output | 1 | Core clock enable before latching |
| osc_en | output | 1 | Oscillator enable |
| tmr_clk_en | output | 1 | Counter/timer clock enable |
| mode | output | 2 | 00 run, 01 light, 10 deep, 11 warm-up |
| wake_irq | output | 1 | One-cycle pulse: resume through interrupt service |
| wake_rst | output | 1 | One-cycle pulse: restart at restart_pc |
| restart_pc | output | 16 | Restart address, 16'h000C |
| flush_miss | output | 1 | Sticky: a sleep opcode came without a preceding no-op |

## Verification
The interesting collision is an enabled interrupt request and a reset wake arriving in the same cycle during deep sleep. The bench raises both together. The reset wake must win, with `mode` moving to warm-up and `wake_irq` staying low. The same pair is also driven in light sleep and in run. In light sleep the interrupt alone must decide the outcome. In run neither may produce a wake pulse.

// File: rtl/slp_pkg.sv
package slp_pkg;

    localparam logic [7:0]  OP_NOP     = 8'hFF;
    localparam logic [7:0]  OP_LIGHT   = 8'h7F;
    localparam logic [7:0]  OP_DEEP    = 8'h6F;
    localparam logic [15:0] RESTART_PC = 16'h000C;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_FLUSH_L,
        ST_FLUSH_D,
        ST_LIGHT,
        ST_DEEP,
        ST_WARM
    } slp_state_t;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_LIGHT = 2'b01,
        MODE_DEEP  = 2'b10,
        MODE_WARM  = 2'b11
    } slp_mode_t;

endpackage

// File: rtl/slp_op_watch.sv
module slp_op_watch
    import slp_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid,
    input  logic [OP_W-1:0] fetch_op,
    output logic            light_hit,
    output logic            deep_hit,
    output logic            nop_seen
);

    // Remembers whether the last valid opcode was the no-op
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nop_seen <= 1'b0;
        end else if (fetch_valid) begin
            nop_seen <= (fetch_op == OP_NOP);
        end
    end

    assign light_hit = fetch_valid && (fetch_op == OP_LIGHT);
    assign deep_hit  = fetch_valid && (fetch_op == OP_DEEP);

    // R10
    nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> $stable(nop_seen));

    // R10
    nop_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_op != OP_NOP) |=> !nop_seen);

endmodule

// File: rtl/slp_warm_timer.sv
module slp_warm_timer #(
    parameter int CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(CYCLES - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign done = (cnt == '0);

    // R6
    warm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt == CW'(CYCLES - 1)));

    // R6
    warm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

endmodule

// File: rtl/slp_clk_gate.sv
module slp_clk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic gclk
);

    logic en_lat;

    // Transparent only while clk is low, so the enable is frozen for the high phase
    always_latch begin
        if (!clk) begin
            en_lat = en;
        end
    end

    assign gclk = clk & en_lat;

    // R8
    gate_phase_chk: assert property (@(negedge clk) disable iff (!rst_n)
        gclk == $past(en));

endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
    import slp_pkg::*;
#(
    parameter int NUM_IRQ     = 4,
    parameter int WARM_CYCLES = 1024,
    parameter int OP_W        = 8,
    parameter int PC_W        = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_valid,
    input  logic [OP_W-1:0]    fetch_op,
    input  logic               pipe_empty,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               rst_wake,
    output logic               cpu_clk,
    output logic               cpu_clk_en,
    output logic               osc_en,
    output logic               tmr_clk_en,
    output logic [1:0]         mode,
    output logic               wake_irq,
    output logic               wake_rst,
    output logic [PC_W-1:0]    restart_pc,
    output logic               flush_miss
);

    slp_state_t st_q, st_d;
    logic       light_hit, deep_hit, nop_seen;
    logic       irq_hit, warm_start, warm_done, miss_set;
    slp_mode_t  mode_c;

    slp_op_watch #(.OP_W(OP_W)) u_watch (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .fetch_op    (fetch_op),
        .light_hit   (light_hit),
        .deep_hit    (deep_hit),
        .nop_seen    (nop_seen)
    );

    slp_warm_timer #(.CYCLES(WARM_CYCLES)) u_warm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (warm_start),
        .done  (warm_done)
    );

    slp_clk_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cpu_clk_en),
        .gclk  (cpu_clk)
    );

    assign irq_hit    = |(irq_req & irq_en);
    assign warm_start = (st_q == ST_DEEP) && rst_wake;
    assign miss_set   = (st_q == ST_RUN) && (light_hit || deep_hit) && !nop_seen;
    assign restart_pc = PC_W'(RESTART_PC);

    // Next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (deep_hit) begin
                    st_d = nop_seen ? ST_DEEP : ST_FLUSH_D;
                end else if (light_hit) begin
                    st_d = nop_seen ? ST_LIGHT : ST_FLUSH_L;
                end
            end
            ST_FLUSH_L: if (pipe_empty) st_d = ST_LIGHT;
            ST_FLUSH_D: if (pipe_empty) st_d = ST_DEEP;
            ST_LIGHT:   if (irq_hit)    st_d = ST_RUN;
            ST_DEEP:    if (rst_wake)   st_d = ST_WARM;
            ST_WARM:    if (warm_done)  st_d = ST_RUN;
            default:                    st_d = ST_RUN;
        endcase
    end

    // State register with its registered side results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_RUN;
            wake_irq   <= 1'b0;
            wake_rst   <= 1'b0;
            flush_miss <= 1'b0;
        end else begin
            st_q       <= st_d;
            wake_irq   <= (st_q == ST_LIGHT) && irq_hit;
            wake_rst   <= (st_q == ST_WARM) && warm_done;
            flush_miss <= flush_miss || miss_set;
        end
    end

    // Output decode
    always_comb begin
        cpu_clk_en = 1'b1;
        osc_en     = 1'b1;
        tmr_clk_en = 1'b1;
        mode_c     = MODE_RUN;
        unique case (st_q)
            ST_RUN, ST_FLUSH_L, ST_FLUSH_D: begin
                mode_c = MODE_RUN;
            end
            ST_LIGHT: begin
                cpu_clk_en = 1'b0;
                mode_c     = MODE_LIGHT;
            end
            ST_DEEP: begin
                cpu_clk_en = 1'b0;
                osc_en     = 1'b0;
                tmr_clk_en = 1'b0;
                mode_c     = MODE_DEEP;
            end
            ST_WARM: begin
                cpu_clk_en = 1'b0;
                tmr_clk_en = 1'b0;
                mode_c     = MODE_WARM;
            end
            default: begin
                mode_c = MODE_RUN;
            end
        endcase
    end

    assign mode = mode_c;

    // R2
    light_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && light_hit && !deep_hit && nop_seen) |=> (mode == MODE_LIGHT && osc_en));

    // R3
    deep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && deep_hit && nop_seen) |=> (mode == MODE_DEEP && !osc_en));

    // R4
    light_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LIGHT && irq_hit) |=> (wake_irq && cpu_clk_en));

    // R4
    light_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LIGHT && !irq_hit) |=> (mode == MODE_LIGHT));

    // R5
    deep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DEEP && !rst_wake) |=> (mode == MODE_DEEP && !wake_irq));

    // R5
    deep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DEEP && rst_wake) |=> (mode == MODE_WARM && osc_en && !cpu_clk_en));

    // R6
    warm_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rst |-> ($past(st_q) == ST_WARM && mode == MODE_RUN));

    // R7
    flush_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_miss |=> flush_miss);

    // R7
    flush_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_FLUSH_L || st_q == ST_FLUSH_D) && !pipe_empty) |=> (mode == MODE_RUN && cpu_clk_en));

    // R9
    wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> ($past(st_q) == ST_LIGHT));

    // R1
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wake_irq && wake_rst));

endmodule

// File: tb/tb_slp_ctrl.sv
module tb_slp_ctrl;

    localparam int NI   = 4;
    localparam int WARM = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [7:0]    fetch_op = 8'h00;
    logic          pipe_empty = 1'b0;
    logic [NI-1:0] irq_req = '0;
    logic [NI-1:0] irq_en = '0;
    logic          rst_wake = 1'b0;
    logic          cpu_clk, cpu_clk_en, osc_en, tmr_clk_en;
    logic [1:0]    mode;
    logic          wake_irq, wake_rst, flush_miss;
    logic [15:0]   restart_pc;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    slp_ctrl #(.NUM_IRQ(NI), .WARM_CYCLES(WARM)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .fetch_op    (fetch_op),
        .pipe_empty  (pipe_empty),
        .irq_req     (irq_req),
        .irq_en      (irq_en),
        .rst_wake    (rst_wake),
        .cpu_clk     (cpu_clk),
        .cpu_clk_en  (cpu_clk_en),
        .osc_en      (osc_en),
        .tmr_clk_en  (tmr_clk_en),
        .mode        (mode),
        .wake_irq    (wake_irq),
        .wake_rst    (wake_rst),
        .restart_pc  (restart_pc),
        .flush_miss  (flush_miss)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 200000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Inputs change and outputs are sampled 2 ns after each rising edge
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic send_op(input logic [7:0] op);
        fetch_valid = 1'b1;
        fetch_op    = op;
        tick();
        fetch_valid = 1'b0;
        fetch_op    = 8'h00;
    endtask

    task automatic wake_by_irq();
        irq_req = 4'b0001;
        irq_en  = 4'b0001;
        tick();
        irq_req = '0;
        irq_en  = '0;
    endtask

    task automatic run_warmup(input string tag);
        int n = 1;
        while (mode == 2'b11 && n < 10 * WARM) begin
            tick();
            if (mode == 2'b11) n++;
        end
        chk({tag, " warm-up length"}, n, WARM);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        chk("R1 mode in reset", mode, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 mode", mode, 0);
        chk("R1 cpu_clk_en", cpu_clk_en, 1);
        chk("R1 osc_en", osc_en, 1);
        chk("R1 tmr_clk_en", tmr_clk_en, 1);
        chk("R1 flush_miss", flush_miss, 0);
        chk("R1 wake pulses", {wake_irq, wake_rst}, 0);
        chk("R1 restart_pc", restart_pc, 16'h000C);
    endtask

    task automatic t_light();
        send_op(8'hFF);
        send_op(8'h7F);
        chk("R2 mode light", mode, 1);
        chk("R2 cpu_clk_en", cpu_clk_en, 0);
        chk("R2 osc_en", osc_en, 1);
        chk("R2 tmr_clk_en", tmr_clk_en, 1);
        chk("R8 pulse on entry edge", cpu_clk, 1);
        tick();
        chk("R8 no pulse while asleep", cpu_clk, 0);
        irq_req = 4'b0010;
        irq_en  = 4'b1101;
        repeat (4) tick();
        chk("R4 masked request keeps sleep", mode, 1);
        chk("R4 no wake pulse when masked", wake_irq, 0);
        rst_wake = 1'b1;
        tick();
        rst_wake = 1'b0;
        chk("R9 rst_wake ignored in light", mode, 1);
        irq_en = 4'b0010;
        tick();
        irq_req = '0;
        irq_en  = '0;
        chk("R4 mode after wake", mode, 0);
        chk("R4 cpu_clk_en after wake", cpu_clk_en, 1);
        chk("R4 wake_irq pulse", wake_irq, 1);
        chk("R8 no pulse on wake edge", cpu_clk, 0);
        tick();
        chk("R4 wake_irq one cycle", wake_irq, 0);
        chk("R8 pulse resumes", cpu_clk, 1);
    endtask

    task automatic t_deep();
        send_op(8'hFF);
        send_op(8'h6F);
        chk("R3 mode deep", mode, 2);
        chk("R3 enables off", {cpu_clk_en, osc_en, tmr_clk_en}, 0);
        irq_req = 4'b1111;
        irq_en  = 4'b1111;
        repeat (3) tick();
        chk("R5 irq ignored in deep", mode, 2);
        chk("R5 no wake_irq in deep", wake_irq, 0);
        rst_wake = 1'b1;
        tick();
        rst_wake = 1'b0;
        irq_req  = '0;
        irq_en   = '0;
        chk("R5 warm-up mode", mode, 3);
        chk("R5 osc_en on", osc_en, 1);
        chk("R5 cpu_clk_en off", cpu_clk_en, 0);
        chk("R5 tmr_clk_en off", tmr_clk_en, 0);
        chk("R5 reset beats irq", wake_irq, 0);
        run_warmup("R6");
        chk("R6 mode run", mode, 0);
        chk("R6 wake_rst pulse", wake_rst, 1);
        chk("R6 enables on", {cpu_clk_en, osc_en, tmr_clk_en}, 7);
        chk("R6 restart_pc", restart_pc, 16'h000C);
        tick();
        chk("R6 wake_rst one cycle", wake_rst, 0);
    endtask

    task automatic t_run_ignore();
        irq_req  = 4'b0100;
        irq_en   = 4'b0100;
        rst_wake = 1'b1;
        repeat (2) tick();
        irq_req  = '0;
        irq_en   = '0;
        rst_wake = 1'b0;
        chk("R9 mode stays run", mode, 0);
        chk("R9 no wake pulses", {wake_irq, wake_rst}, 0);
        chk("R9 osc_en", osc_en, 1);
    endtask

    task automatic t_flush();
        send_op(8'h00);
        send_op(8'h7F);
        chk("R7 mode held run", mode, 0);
        chk("R7 cpu_clk_en held", cpu_clk_en, 1);
        chk("R7 flush_miss set", flush_miss, 1);
        repeat (3) tick();
        chk("R7 waits for pipe_empty", mode, 0);
        pipe_empty = 1'b1;
        tick();
        pipe_empty = 1'b0;
        chk("R7 light after pipe_empty", mode, 1);
        wake_by_irq();
        chk("R7 woke", mode, 0);
        chk("R7 flush_miss sticky", flush_miss, 1);
    endtask

    task automatic t_pairing();
        send_op(8'hFF);
        repeat (2) tick();
        send_op(8'h7F);
        chk("R10 idle gap keeps pairing", mode, 1);
        wake_by_irq();
        chk("R10 woke", mode, 0);
        send_op(8'hFF);
        send_op(8'h00);
        send_op(8'h6F);
        chk("R10 other opcode breaks pairing", mode, 0);
        chk("R10 cpu_clk_en still on", cpu_clk_en, 1);
        pipe_empty = 1'b1;
        tick();
        pipe_empty = 1'b0;
        chk("R10 deep after flush", mode, 2);
        rst_wake = 1'b1;
        tick();
        rst_wake = 1'b0;
        chk("R10 warm-up", mode, 3);
        run_warmup("R10");
        chk("R10 back to run", mode, 0);
    endtask

    initial begin
        t_reset();
        t_light();
        t_deep();
        t_run_ignore();
        t_flush();
        t_pairing();
        repeat (2) tick();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule